// File: doc/BRIEF.md
# Spindle Frame-Sync Lock Detector

This block decides whether the constant-linear-velocity spindle loop is synchronized to the data coming off the disc. It runs on the write frame clock. An internal phase counter wraps once every `DECIM` frame clocks, and each wrap marks where a detected frame sync is expected. On that cycle, called the sample strobe, the block checks whether the sync detector has fired. A hit counts as agreement. A quiet strobe counts as disagreement.

A run of `MISS_LIMIT` disagreements in a row moves the block to the unlocked state. Any agreement puts it back in the locked state. The lock flag picks the spindle servo variant: the lead-in servo while unlocked and the regular servo while locked. While unlocked, the phase counter re-aligns to each off-phase sync it sees, so that the next strobe lands one period after that sync. While locked, the phase is held fixed and stray syncs are ignored.

Top module: `fsync_lock_det`

## Requirements
- R1: After reset `locked` is 0, `servo_mode` is 0 (lead-in), the miss count is cleared and the phase is zero. Without re-alignment, the first sample strobe falls on the `DECIM`-th rising clock edge after reset is released.
- R2: Agreement is sampled only on the strobe, once every `DECIM` (default 16) frame clocks. While locked, a `sync_det` pulse on any other cycle has no effect on the outputs.
- R3: `sync_det` high on a strobe edge sets `locked` to 1 from that edge onward and clears the consecutive-miss count.
- R4: The `MISS_LIMIT`-th (default 8) strobe in a row without `sync_det` clears `locked` at that edge.
- R5: One agreement between runs of misses restarts the count. Seven misses, one hit and seven more misses leave `locked` at 1.
- R6: While unlocked, `sync_det` on a cycle other than the strobe restarts the phase. The next strobe is then the `DECIM`-th edge after that pulse.
- R7: While locked, an off-phase `sync_det` does not move the phase. Syncs that arrive only off-phase are counted as misses and eventually drop the lock.
- R8: `servo_mode` is 1 (regular servo) when locked and 0 (lead-in servo) when unlocked. `locked` and `servo_mode` change only on strobe edges.
- R9: Further misses while unlocked keep the block unlocked, and the miss count saturates at `MISS_LIMIT` without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write frame clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_det | input | 1 | Detected frame sync pulse, one clock wide |
| locked | output | 1 | 1 = synchronous, 0 = asynchronous |
| servo_mode | output | 1 | 1 = regular servo, 0 = lead-in servo |

## Verification
The bench first walks a stimulus table of strobe outcomes. The table contains runs of seven misses broken by a single hit: a design that never cleared its miss count would drop lock there. It also contains an eighth miss, which must unlock, and further misses afterwards: a counter that wraps would report a false re-lock.

Directed tests then cover the rest. An off-phase sync is placed inside a locked period: a design that re-aligned while locked would stay locked forever, or would change its outputs between strobes. An off-phase sync is also placed while unlocked: a design without re-alignment would miss the shifted strobe and stay in lead-in. Finally, reset is asserted in the middle of a lock, and the outputs must return to the lead-in state.

// File: rtl/fsld_pkg.sv
package fsld_pkg;
   // servo variant select encoding
   localparam logic MODE_LEADIN  = 1'b0;
   localparam logic MODE_REGULAR = 1'b1;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/fsld_phase.sv
module fsld_phase #(
   parameter int unsigned DECIM = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_det,
   input  logic realign_en,
   output logic strobe
);
   localparam int unsigned PW = fsld_pkg::cnt_width(DECIM);
   localparam logic [PW-1:0] LAST = PW'(DECIM - 1);
   localparam bit IS_POW2 = ((DECIM & (DECIM - 1)) == 0);

   logic [PW-1:0] ph_q;
   logic [PW-1:0] ph_next;

   assign strobe = (ph_q == LAST);

   generate
      if (IS_POW2) begin : g_wrap_natural
         assign ph_next = ph_q + 1'b1;
      end else begin : g_wrap_compare
         assign ph_next = strobe ? '0 : ph_q + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q <= '0;
      end else if (realign_en && sync_det && !strobe) begin
         ph_q <= '0;
      end else begin
         ph_q <= ph_next;
      end
   end
endmodule

// File: rtl/fsld_miss.sv
module fsld_miss #(
   parameter int unsigned MISS_LIMIT = 8,
   localparam int unsigned MW = fsld_pkg::cnt_width(MISS_LIMIT + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          strobe,
   input  logic          agree,
   output logic          locked,
   output logic [MW-1:0] miss_cnt
);
   localparam logic [MW-1:0] LIMIT   = MW'(MISS_LIMIT);
   localparam logic [MW-1:0] LIMIT_M = MW'(MISS_LIMIT - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked   <= 1'b0;
         miss_cnt <= '0;
      end else if (strobe) begin
         if (agree) begin
            locked   <= 1'b1;
            miss_cnt <= '0;
         end else if (miss_cnt != LIMIT) begin
            miss_cnt <= miss_cnt + 1'b1;
            if (miss_cnt == LIMIT_M) begin
               locked <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/fsync_lock_det.sv
module fsync_lock_det #(
   parameter int unsigned DECIM      = 16,
   parameter int unsigned MISS_LIMIT = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_det,
   output logic locked,
   output logic servo_mode
);
   localparam int unsigned MW = fsld_pkg::cnt_width(MISS_LIMIT + 1);

   generate
      if (DECIM < 2) begin : g_bad_decim
         $error("DECIM must be at least 2");
      end
      if (MISS_LIMIT < 1) begin : g_bad_limit
         $error("MISS_LIMIT must be at least 1");
      end
   endgenerate

   logic          strobe;
   logic          locked_q;
   logic [MW-1:0] miss_cnt;

   fsld_phase #(.DECIM(DECIM)) u_phase (
      .clk        (clk),
      .rst_n      (rst_n),
      .sync_det   (sync_det),
      .realign_en (!locked_q),
      .strobe     (strobe)
   );

   fsld_miss #(.MISS_LIMIT(MISS_LIMIT)) u_miss (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (strobe),
      .agree    (sync_det),
      .locked   (locked_q),
      .miss_cnt (miss_cnt)
   );

   assign locked     = locked_q;
   assign servo_mode = locked_q ? fsld_pkg::MODE_REGULAR : fsld_pkg::MODE_LEADIN;
endmodule

// File: rtl/fsync_lock_det_chk.sv
module fsync_lock_det_chk #(
   parameter int unsigned MISS_LIMIT = 8,
   localparam int unsigned MW = fsld_pkg::cnt_width(MISS_LIMIT + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sync_det,
   input logic          strobe,
   input logic          locked,
   input logic          servo_mode,
   input logic [MW-1:0] miss_cnt
);
   localparam logic [MW-1:0] LIMIT   = MW'(MISS_LIMIT);
   localparam logic [MW-1:0] LIMIT_M = MW'(MISS_LIMIT - 1);

   AST_STROBE_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe); // R2
   AST_LOCK_HELD_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(locked)); // R8
   AST_MODE_HELD_OFF_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      !strobe |=> $stable(servo_mode)); // R8
   AST_AGREE_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      strobe && sync_det |=> locked && (miss_cnt == '0)); // R3
   AST_LIMIT_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      strobe && !sync_det && (miss_cnt == LIMIT_M) |=> !locked); // R4
   AST_SHORT_RUN_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      locked && strobe && !sync_det && (miss_cnt < LIMIT_M) |=> locked); // R5
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      miss_cnt <= LIMIT); // R9
endmodule

bind fsync_lock_det fsync_lock_det_chk #(.MISS_LIMIT(MISS_LIMIT)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sync_det   (sync_det),
   .strobe     (strobe),
   .locked     (locked),
   .servo_mode (servo_mode),
   .miss_cnt   (miss_cnt)
);

// File: tb/fsync_lock_det_tb.sv
module fsync_lock_det_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DECIM      = 16;
   localparam int NVEC       = 20;
   // bit1: sync at strobe, bit0: expected locked after that strobe
   localparam logic [1:0] VEC [NVEC] = '{
      2'b00, 2'b11, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b11,
      2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b01, 2'b00, 2'b00, 2'b11};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_det = 1'b0;
   logic locked;
   logic servo_mode;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fsync_lock_det u_dut (
      .clk(clk), .rst_n(rst_n), .sync_det(sync_det),
      .locked(locked), .servo_mode(servo_mode));

   task automatic chk(input string req, input logic act_l, input logic exp_l);
      checks++;
      if (act_l !== exp_l || servo_mode !== exp_l) begin
         errors++;
         $display("FAIL %s: locked=%b servo_mode=%b expected %b", req, act_l, servo_mode, exp_l);
      end
   endtask

   task automatic step(input logic s);
      sync_det = s;
      @(posedge clk);
      @(negedge clk);
      sync_det = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset", locked, 1'b0);
      rst_n = 1'b1;

      // table walk: 15 quiet cycles then the strobe cycle
      for (int v = 0; v < NVEC; v++) begin
         for (int i = 0; i < DECIM - 1; i++) step(1'b0);
         chk("R8 between strobes", locked, (v == 0) ? 1'b0 : VEC[v-1][0]);
         step(VEC[v][1]);
         chk($sformatf("R1 R3 R4 R5 R9 vector %0d", v), locked, VEC[v][0]);
      end

      // R7/R2: locked, sync only off-phase
      for (int p = 0; p < 8; p++) begin
         for (int i = 0; i < 7; i++) step(1'b0);
         step(1'b1);
         chk("R2 off-phase sync ignored", locked, 1'b1);
         for (int i = 0; i < DECIM - 9; i++) step(1'b0);
         step(1'b0);
         chk("R7 off-phase misses while locked", locked, (p == 7) ? 1'b0 : 1'b1);
      end

      // R6: unlocked, off-phase sync re-aligns
      for (int i = 0; i < 4; i++) step(1'b0);
      step(1'b1);
      for (int i = 0; i < DECIM - 1; i++) step(1'b0);
      chk("R6 before shifted strobe", locked, 1'b0);
      step(1'b1);
      chk("R6 shifted strobe locks", locked, 1'b1);

      // reset while locked
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 reset while locked", locked, 1'b0);
      rst_n = 1'b1;
      for (int i = 0; i < DECIM - 1; i++) step(1'b0);
      step(1'b1);
      chk("R1 first strobe after reset", locked, 1'b1);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule